// File: doc/BRIEF.md
# 32-bit SEC-DED Hamming Codec

This block protects a 32-bit memory word with a 7-bit check word. The code corrects any single-bit error and detects any double-bit error. The encoder side takes a data word and returns the check word to store beside it. The decoder side takes a 39-bit word read back from memory and returns four things: a 7-bit active-low syndrome, an active-low single-error flag, an active-low multiple-error flag, and the data word with any single data-bit error repaired. Both paths are purely combinational. Any latching, bus turnaround or partial-word write sequencing is left to the surrounding datapath controller.

Every check bit is the parity of 16 data bits. Check groups 0 and 1 use odd parity, so a word of all zeros and a word of all ones are never valid codewords.

The decoder regenerates the check word from the received data and XORs it with the received check word to form a difference vector. It then places the word in exactly one of five error classes. The conditions are tested in the order below, and the first one that holds selects the class:

- **CLEAN**: the difference is zero.
- **EVEN_MULTI**: the difference is non-zero and has even weight.
- **CHECK_FLIP**: the difference has exactly one bit set.
- **DATA_FLIP**: the difference equals the column of some data bit.
- **ODD_MULTI**: any other odd-weight difference.

The flag outputs and the correction mask are decoded from the class with a unique case.

Top module: `secded32_codec`

## Requirements
- R1: `enc_check_o[k]` is the XOR of every data bit `i` whose R2 syndrome code has a 0 at bit `k`, inverted for `k` = 0 and `k` = 1. Each of the 7 groups covers exactly 16 data bits.
- R2: Syndrome bit `k` is low exactly when the received check bit `k` differs from the regenerated one. Codes are written bit 6 to bit 0. A single error in data bit `i` gives the following code, drives `single_err_n_o` low, leaves `multi_err_n_o` high, and restores bit `i` in `dec_data_o`:
  0:0110000 1:0110101 2:0101101 3:0101011 4:0101000 5:0100111 6:0100100 7:0100010 8:1011100 9:1011010 10:1011001 11:1010110 12:1010101 13:1010011 14:1001110 15:1001011 16:1110001 17:1110100 18:1101100 19:1101010 20:1101001 21:1100110 22:1100101 23:1100011 24:0011101 25:0011011 26:0011000 27:0010111 28:0010100 29:0010010 30:0001111 31:0001010
- R3: A valid codeword gives syndrome 1111111, both flags high, and `dec_data_o` equal to `dec_data_i`.
- R4: A single error in check bit `k` gives a syndrome that is all ones except a 0 at bit `k`. `single_err_n_o` is low, `multi_err_n_o` is high, and the data passes through unchanged.
- R5: A non-zero difference of even weight, which includes every double error, drives both flags low and passes the data through unchanged.
- R6: `dec_data_o` differs from `dec_data_i` in at most one bit, and only in the DATA_FLIP class.
- R7: A 39-bit word of all zeros gives syndrome 1111100. A 39-bit word of all ones gives syndrome 0000011. Both words drive both flags low.
- R8: An odd-weight difference that is neither a single bit nor a data column drives both flags low and passes the data through unchanged.
- R9: The encoder and decoder paths are independent. Both produce correct results for unrelated words presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 32 | Data word to encode |
| enc_check_o | output | 7 | Check word for `enc_data_i` |
| dec_data_i | input | 32 | Data word read from memory |
| dec_check_i | input | 7 | Check word read from memory |
| dec_data_o | output | 32 | Data word after correction |
| syndrome_n_o | output | 7 | Active-low syndrome; all ones means no error |
| single_err_n_o | output | 1 | Low when any error is seen |
| multi_err_n_o | output | 1 | Low when the error cannot be corrected |

## Verification
Two functions can fall in the same cycle. The first is the encoder working on one word while the decoder repairs a corrupted, unrelated word. The bench provokes this by driving a fresh encoder pattern on every step of the single-error sweep and judging both outputs at the same sample point. The second is syndrome reporting combined with correction. For each data-bit error, the bench judges the syndrome code, the flag pair and the restored word together against a reference built from the code map.

// File: rtl/secded32_pkg.sv
package secded32_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;

    // Check groups that use odd parity
    localparam logic [CHK_W-1:0] ODD_GROUPS = 7'b0000011;

    typedef enum logic [2:0] {
        CLS_CLEAN,
        CLS_CHECK_FLIP,
        CLS_DATA_FLIP,
        CLS_EVEN_MULTI,
        CLS_ODD_MULTI
    } err_class_t;

    // Active-low syndrome produced by a single error in data bit idx
    function automatic logic [CHK_W-1:0] syn_code(input int idx);
        logic [CHK_W-1:0] c;
        case (idx)
            0:  c = 7'b0110000;
            1:  c = 7'b0110101;
            2:  c = 7'b0101101;
            3:  c = 7'b0101011;
            4:  c = 7'b0101000;
            5:  c = 7'b0100111;
            6:  c = 7'b0100100;
            7:  c = 7'b0100010;
            8:  c = 7'b1011100;
            9:  c = 7'b1011010;
            10: c = 7'b1011001;
            11: c = 7'b1010110;
            12: c = 7'b1010101;
            13: c = 7'b1010011;
            14: c = 7'b1001110;
            15: c = 7'b1001011;
            16: c = 7'b1110001;
            17: c = 7'b1110100;
            18: c = 7'b1101100;
            19: c = 7'b1101010;
            20: c = 7'b1101001;
            21: c = 7'b1100110;
            22: c = 7'b1100101;
            23: c = 7'b1100011;
            24: c = 7'b0011101;
            25: c = 7'b0011011;
            26: c = 7'b0011000;
            27: c = 7'b0010111;
            28: c = 7'b0010100;
            29: c = 7'b0010010;
            30: c = 7'b0001111;
            31: c = 7'b0001010;
            default: c = '1;
        endcase
        return c;
    endfunction

    // Active-high column: the check groups that cover data bit idx
    function automatic logic [CHK_W-1:0] column(input int idx);
        return ~syn_code(idx);
    endfunction

    // Data bits that feed check group k
    function automatic logic [DATA_W-1:0] group_mask(input int k);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  col;
        for (int i = 0; i < DATA_W; i++) begin
            col  = column(i);
            m[i] = col[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded32_parity_gen.sv
module secded32_parity_gen
    import secded32_pkg::*;
#(
    parameter int               DW     = DATA_W,
    parameter int               CW     = CHK_W,
    parameter logic [CW-1:0]    INVERT = ODD_GROUPS
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] check_o
);

    for (genvar k = 0; k < CW; k++) begin : g_group
        localparam logic [DW-1:0] MASK = DW'(group_mask(k));
        assign check_o[k] = (^(data_i & MASK)) ^ INVERT[k];
    end

endmodule

// File: rtl/secded32_classify.sv
module secded32_classify
    import secded32_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [CW-1:0] diff_i,
    output logic [DW-1:0] hit_o,
    output err_class_t    cls_o
);

    logic odd_weight;
    logic one_bit;
    logic any_hit;

    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [CW-1:0] COL = CW'(column(i));
        assign hit_o[i] = (diff_i == COL);
    end

    assign odd_weight = ^diff_i;
    assign one_bit    = ((diff_i & (diff_i - 1'b1)) == '0);
    assign any_hit    = |hit_o;

    always_comb begin
        if (diff_i == '0) begin
            cls_o = CLS_CLEAN;
        end else if (!odd_weight) begin
            cls_o = CLS_EVEN_MULTI;
        end else if (one_bit) begin
            cls_o = CLS_CHECK_FLIP;
        end else if (any_hit) begin
            cls_o = CLS_DATA_FLIP;
        end else begin
            cls_o = CLS_ODD_MULTI;
        end
    end

endmodule

// File: rtl/secded32_correct.sv
module secded32_correct
    import secded32_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] hit_i,
    input  err_class_t    cls_i,
    output logic [DW-1:0] data_o,
    output logic          single_n_o,
    output logic          multi_n_o
);

    logic [DW-1:0] flip;

    always_comb begin
        flip       = '0;
        single_n_o = 1'b1;
        multi_n_o  = 1'b1;
        unique case (cls_i)
            CLS_CLEAN: begin
                single_n_o = 1'b1;
                multi_n_o  = 1'b1;
            end
            CLS_CHECK_FLIP: begin
                single_n_o = 1'b0;
            end
            CLS_DATA_FLIP: begin
                single_n_o = 1'b0;
                flip       = hit_i;
            end
            CLS_EVEN_MULTI, CLS_ODD_MULTI: begin
                single_n_o = 1'b0;
                multi_n_o  = 1'b0;
            end
            default: begin
                single_n_o = 1'b0;
                multi_n_o  = 1'b0;
            end
        endcase
    end

    assign data_o = data_i ^ flip;

endmodule

// File: rtl/secded32_codec.sv
module secded32_codec
    import secded32_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] enc_data_i,
    output logic [CW-1:0] enc_check_o,
    input  logic [DW-1:0] dec_data_i,
    input  logic [CW-1:0] dec_check_i,
    output logic [DW-1:0] dec_data_o,
    output logic [CW-1:0] syndrome_n_o,
    output logic          single_err_n_o,
    output logic          multi_err_n_o
);

    logic [CW-1:0] regen;
    logic [CW-1:0] diff;
    logic [DW-1:0] hit;
    err_class_t    cls;

    secded32_parity_gen #(.DW(DW), .CW(CW)) u_enc (
        .data_i  (enc_data_i),
        .check_o (enc_check_o)
    );

    secded32_parity_gen #(.DW(DW), .CW(CW)) u_regen (
        .data_i  (dec_data_i),
        .check_o (regen)
    );

    assign diff         = dec_check_i ^ regen;
    assign syndrome_n_o = ~diff;

    secded32_classify #(.DW(DW), .CW(CW)) u_cls (
        .diff_i (diff),
        .hit_o  (hit),
        .cls_o  (cls)
    );

    secded32_correct #(.DW(DW)) u_fix (
        .data_i     (dec_data_i),
        .hit_i      (hit),
        .cls_i      (cls),
        .data_o     (dec_data_o),
        .single_n_o (single_err_n_o),
        .multi_n_o  (multi_err_n_o)
    );

endmodule

// File: rtl/secded32_codec_chk.sv
module secded32_codec_chk #(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input logic [DW-1:0] dec_data_i,
    input logic [CW-1:0] dec_check_i,
    input logic [DW-1:0] dec_data_o,
    input logic [CW-1:0] syndrome_n_o,
    input logic          single_err_n_o,
    input logic          multi_err_n_o
);

    int unsigned diff_w;
    int unsigned flip_w;

    always_comb begin
        diff_w = $countones(~syndrome_n_o);
        flip_w = $countones(dec_data_o ^ dec_data_i);

        AST_FLAGS_ORDERED: assert (multi_err_n_o || !single_err_n_o)
            else $error("multi-error flag low without single-error flag"); // R5

        AST_CLEAN_QUIET: assert (diff_w != 0 ||
                                 (single_err_n_o && multi_err_n_o && flip_w == 0))
            else $error("clean syndrome with flags or change"); // R3

        AST_ONE_FLIP_MAX: assert (flip_w <= 1)
            else $error("more than one data bit changed"); // R6

        AST_FIX_WEIGHT: assert (flip_w == 0 ||
                                ((diff_w == 3 || diff_w == 5) && !single_err_n_o && multi_err_n_o))
            else $error("correction without a data-column syndrome"); // R2

        AST_CHECK_SLIP: assert (diff_w != 1 ||
                                (!single_err_n_o && multi_err_n_o && flip_w == 0))
            else $error("check-bit error mishandled"); // R4

        AST_EVEN_DOUBLE: assert (diff_w == 0 || diff_w[0] ||
                                 (!single_err_n_o && !multi_err_n_o))
            else $error("even-weight syndrome not flagged uncorrectable"); // R5

        AST_MULTI_HOLDS: assert (multi_err_n_o || flip_w == 0)
            else $error("uncorrectable word was altered"); // R8

        AST_ZERO_WORD: assert (dec_data_i != '0 || dec_check_i != '0 || !multi_err_n_o)
            else $error("all-zero word not flagged"); // R7
    end

endmodule

bind secded32_codec secded32_codec_chk #(.DW(DW), .CW(CW)) u_chk (
    .dec_data_i     (dec_data_i),
    .dec_check_i    (dec_check_i),
    .dec_data_o     (dec_data_o),
    .syndrome_n_o   (syndrome_n_o),
    .single_err_n_o (single_err_n_o),
    .multi_err_n_o  (multi_err_n_o)
);

// File: tb/secded32_codec_test.sv
`timescale 1ns/1ps
module secded32_codec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [6:0]  enc_check_o;
    logic [31:0] dec_data_i = '0;
    logic [6:0]  dec_check_i = '0;
    logic [31:0] dec_data_o;
    logic [6:0]  syndrome_n_o;
    logic        single_err_n_o;
    logic        multi_err_n_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    secded32_codec uut (
        .enc_data_i     (enc_data_i),
        .enc_check_o    (enc_check_o),
        .dec_data_i     (dec_data_i),
        .dec_check_i    (dec_check_i),
        .dec_data_o     (dec_data_o),
        .syndrome_n_o   (syndrome_n_o),
        .single_err_n_o (single_err_n_o),
        .multi_err_n_o  (multi_err_n_o)
    );

    // Code map taken from requirement R2
    function automatic logic [6:0] ref_code(input int i);
        logic [6:0] t [32];
        t[0]=7'b0110000;  t[1]=7'b0110101;  t[2]=7'b0101101;  t[3]=7'b0101011;
        t[4]=7'b0101000;  t[5]=7'b0100111;  t[6]=7'b0100100;  t[7]=7'b0100010;
        t[8]=7'b1011100;  t[9]=7'b1011010;  t[10]=7'b1011001; t[11]=7'b1010110;
        t[12]=7'b1010101; t[13]=7'b1010011; t[14]=7'b1001110; t[15]=7'b1001011;
        t[16]=7'b1110001; t[17]=7'b1110100; t[18]=7'b1101100; t[19]=7'b1101010;
        t[20]=7'b1101001; t[21]=7'b1100110; t[22]=7'b1100101; t[23]=7'b1100011;
        t[24]=7'b0011101; t[25]=7'b0011011; t[26]=7'b0011000; t[27]=7'b0010111;
        t[28]=7'b0010100; t[29]=7'b0010010; t[30]=7'b0001111; t[31]=7'b0001010;
        return t[i];
    endfunction

    function automatic logic [6:0] ref_enc(input logic [31:0] d);
        logic [6:0] c;
        logic [6:0] col;
        c = 7'b0000011;
        for (int i = 0; i < 32; i++) begin
            col = ~ref_code(i);
            if (d[i]) c = c ^ col;
        end
        return c;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] d, input logic [6:0] c);
        @(posedge clk);
        dec_data_i  = d;
        dec_check_i = c;
        @(negedge clk);
    endtask

    task automatic check_dec(input string req, input logic [31:0] exp_d,
                             input logic [6:0] exp_s, input logic exp_se,
                             input logic exp_me);
        check(req, "data",     {8'h0, dec_data_o},   {8'h0, exp_d});
        check(req, "syndrome", {33'h0, syndrome_n_o}, {33'h0, exp_s});
        check(req, "flags",    {38'h0, single_err_n_o, multi_err_n_o},
                               {38'h0, exp_se, exp_me});
    endtask

    task automatic t_reset;
        enc_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "zero-data check word", {33'h0, enc_check_o}, {33'h0, 7'b0000011});
        rst_n = 1'b1;
    endtask

    task automatic t_encode;
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001; pats[5] = 32'h0F0F_F0F0;
        for (int p = 0; p < 6; p++) begin
            @(posedge clk);
            enc_data_i = pats[p];
            @(negedge clk);
            check("R1", "check word", {33'h0, enc_check_o}, {33'h0, ref_enc(pats[p])});
            apply(pats[p], ref_enc(pats[p]));
            check_dec("R3", pats[p], 7'h7F, 1'b1, 1'b1);
        end
    endtask

    task automatic t_single_data;
        logic [31:0] base;
        logic [31:0] other;
        base = 32'h3C5A_96E1;
        for (int i = 0; i < 32; i++) begin
            other = 32'hDEAD_0000 ^ (32'h1 << i) ^ i;
            @(posedge clk);
            enc_data_i  = other;
            dec_data_i  = base ^ (32'h1 << i);
            dec_check_i = ref_enc(base);
            @(negedge clk);
            check_dec("R2", base, ref_code(i), 1'b0, 1'b1);
            check("R9", "encoder beside decode", {33'h0, enc_check_o}, {33'h0, ref_enc(other)});
        end
    endtask

    task automatic t_single_check;
        logic [31:0] base;
        base = 32'h7700_11EE;
        for (int k = 0; k < 7; k++) begin
            apply(base, ref_enc(base) ^ (7'h1 << k));
            check_dec("R4", base, ~(7'h1 << k), 1'b0, 1'b1);
        end
    endtask

    task automatic t_double;
        logic [31:0] base;
        logic [31:0] bad;
        base = 32'h5555_CCCC;
        for (int i = 0; i < 31; i += 3) begin
            bad = base ^ (32'h1 << i) ^ (32'h1 << (i + 1));
            apply(bad, ref_enc(base));
            check_dec("R5", bad, ~((~ref_code(i)) ^ (~ref_code(i + 1))), 1'b0, 1'b0);
        end
        for (int k = 0; k < 7; k++) begin
            bad = base ^ (32'h1 << (k * 4));
            apply(bad, ref_enc(base) ^ (7'h1 << k));
            check_dec("R5", bad, ~((~ref_code(k * 4)) ^ (7'h1 << k)), 1'b0, 1'b0);
        end
        apply(base, ref_enc(base) ^ 7'b1000001);
        check_dec("R5", base, 7'b0111110, 1'b0, 1'b0);
    endtask

    task automatic t_gross;
        apply(32'h0, 7'h0);
        check_dec("R7", 32'h0, 7'b1111100, 1'b0, 1'b0);
        apply(32'hFFFF_FFFF, 7'h7F);
        check_dec("R7", 32'hFFFF_FFFF, 7'b0000011, 1'b0, 1'b0);
    endtask

    task automatic t_odd_multi;
        logic [31:0] base;
        base = 32'h0BAD_F00D;
        apply(base, ~ref_enc(base));
        check_dec("R8", base, 7'b0000000, 1'b0, 1'b0);
        apply(base, ref_enc(base) ^ 7'b0000111);
        check_dec("R8", base, 7'b1111000, 1'b0, 1'b0);
        apply(base ^ 32'h1, ref_enc(base) ^ 7'b0110000);
        check_dec("R6", base ^ 32'h1, 7'b0000000, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_encode();
        t_single_data();
        t_single_check();
        t_double();
        t_gross();
        t_odd_multi();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule